// File: doc/BRIEF.md
# Dual-Path Permutation Map Selector

This block keeps a bank of 6-bit substitution maps, each a permutation of the codes 0..63, and applies them to two independent character paths: a forward path and a return path. Each path reads its own 6-bit configuration word, which names one stored map and says whether that map is used as written or backwards (inverse lookup). Only forward permutations are ever stored. A path that asks for the inverse builds it itself from the stored map while it fills its working table.

After reset, each path latches its configuration word in the first clock cycle. It then copies the selected map into a private 64-entry table, scattering the entries when the inverse is requested, and raises its ready flag. From then on it translates one character per cycle with a single register of latency. The map contents are written through a load port. The store is not cleared by reset, so the usual sequence is: load the maps, release the load port, let both tables fill, and translate. A later reset re-fills the tables with a new configuration from the same store contents.

Top module: `perm_sel`

## Requirements
- R1: A configuration word holds the map index in bits [4:0] and the direction in bit [5], where 0 means forward lookup and 1 means inverse lookup. The store holds maps 0 to 20.
- R2: In forward mode, a character s presented with its valid bit produces map[idx][s].
- R3: In inverse mode, a character s produces the unique j for which map[idx][j] equals s.
- R4: The two paths are configured independently. They may select the same map or different maps, in either direction, at the same time.
- R5: A configuration word is sampled only in the first cycle after reset is released. Later changes have no effect until the next reset.
- R6: Each path fills its table in 64 cycles. The fill does not advance in any cycle where the load enable is high. Ready rises on the clock edge that writes the last table entry and then stays high until reset. With the load enable held low, ready is first seen high after the 65th rising edge following reset release.
- R7: While a path is not ready, its output valid stays low whatever its input does.
- R8: A configuration index from 21 to 31 raises that path's error flag after sampling, and the path then returns every character unchanged.
- R9: The load port writes one 6-bit entry per cycle, at (map index, entry index), only while the paths are not ready. A load attempted after ready has no effect on the store.
- R10: The map store keeps its contents through reset.
- R11: A translated character appears on the output, with output valid high, one cycle after the input valid. An idle input cycle gives an idle output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_fwd | input | 6 | Forward-path configuration: direction in bit 5, map index in bits 4:0 |
| cfg_ret | input | 6 | Return-path configuration, same layout as cfg_fwd |
| ld_en | input | 1 | Load request; also holds the table fill |
| ld_map | input | 5 | Map index for the load |
| ld_entry | input | 6 | Entry index within the map |
| ld_data | input | 6 | Entry value to store |
| fwd_in_vld | input | 1 | Forward-path input valid |
| fwd_in_sym | input | 6 | Forward-path input character |
| fwd_out_vld | output | 1 | Forward-path output valid |
| fwd_out_sym | output | 6 | Forward-path translated character |
| ret_in_vld | input | 1 | Return-path input valid |
| ret_in_sym | input | 6 | Return-path input character |
| ret_out_vld | output | 1 | Return-path output valid |
| ret_out_sym | output | 6 | Return-path translated character |
| fwd_ready | output | 1 | Forward-path table complete |
| ret_ready | output | 1 | Return-path table complete |
| fwd_err | output | 1 | Forward-path configuration names a reserved index |
| ret_err | output | 1 | Return-path configuration names a reserved index |

## Verification
The assertions assume that every loaded map is a true permutation of 0..63. The inverse-table scatter and the output checks only make sense on that basis. The stimulus loads each map from an odd-multiplier affine formula, which is always a bijection on 64 codes. The assertions also assume that the configuration words are settled when reset is released. The bench sets them while reset is still high, and it changes them only after ready, to show that the change is ignored. Load attempts after ready are deliberate: they show the store is untouched, and the bench confirms this through lookups both before and after a later reset.

// File: rtl/perm_sel_pkg.sv
package perm_sel_pkg;

    localparam int SYM_W     = 6;
    localparam int IDX_W     = 5;
    localparam int NUM_MAPS  = 21;
    localparam int NUM_PATHS = 2;
    localparam int DEPTH     = 1 << SYM_W;
    localparam int ADDR_W    = IDX_W + SYM_W;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [IDX_W-1:0] idx_t;

    // direction bit sits above the map index
    typedef struct packed {
        logic rev;
        idx_t idx;
    } cfg_t;

    typedef enum logic [1:0] {
        FS_SAMPLE = 2'd0,
        FS_FILL   = 2'd1,
        FS_READY  = 2'd2
    } fill_state_e;

    typedef enum int {
        PATH_FWD = 0,
        PATH_RET = 1
    } path_id_e;

    function automatic logic idx_legal(input idx_t idx);
        return idx < IDX_W'(NUM_MAPS);
    endfunction

    function automatic logic [ADDR_W-1:0] store_addr(input idx_t idx, input sym_t ent);
        return {idx, ent};
    endfunction

endpackage

// File: rtl/perm_map_store.sv
module perm_map_store
    import perm_sel_pkg::*;
#(
    parameter int N_MAPS = NUM_MAPS,
    parameter int N_RD   = NUM_PATHS
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  idx_t wr_map,
    input  sym_t wr_ent,
    input  sym_t wr_data,
    input  idx_t rd_map  [N_RD],
    input  sym_t rd_ent  [N_RD],
    output sym_t rd_data [N_RD]
);

    localparam int ENTRIES = N_MAPS * DEPTH;

    sym_t               mem [ENTRIES];
    logic [ADDR_W-1:0]  wr_addr;
    logic               wr_ok;

    always_comb begin
        wr_addr = store_addr(wr_map, wr_ent);
        wr_ok   = wr_en && (wr_map < IDX_W'(N_MAPS));
    end

    // storage is deliberately left out of reset
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar r = 0; r < N_RD; r++) begin : g_rd
        always_comb begin
            if (rd_map[r] < IDX_W'(N_MAPS)) begin
                rd_data[r] = mem[store_addr(rd_map[r], rd_ent[r])];
            end else begin
                rd_data[r] = '0;
            end
        end
    end

    // R9
    load_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/perm_path.sv
module perm_path
    import perm_sel_pkg::*;
#(
    parameter int W = SYM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cfg_t         cfg_in,
    input  logic         stall,
    output idx_t         rd_map,
    output sym_t         rd_ent,
    input  sym_t         rd_data,
    input  logic         in_vld,
    input  logic [W-1:0] in_sym,
    output logic         out_vld,
    output logic [W-1:0] out_sym,
    output logic         ready,
    output logic         err
);

    localparam int N = 1 << W;

    fill_state_e  state_q;
    cfg_t         cfg_q;
    logic         err_q;
    logic [W-1:0] fill_cnt;
    logic [W-1:0] tbl [N];
    logic [W-1:0] wr_addr;
    logic [W-1:0] wr_val;
    logic         wr_en;
    logic         last_ent;

    always_comb begin
        rd_map   = cfg_q.idx;
        rd_ent   = fill_cnt;
        wr_en    = (state_q == FS_FILL) && !stall;
        last_ent = (fill_cnt == W'(N - 1));
        if (err_q) begin
            wr_addr = fill_cnt;
            wr_val  = fill_cnt;
        end else if (cfg_q.rev) begin
            wr_addr = rd_data;
            wr_val  = fill_cnt;
        end else begin
            wr_addr = fill_cnt;
            wr_val  = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= FS_SAMPLE;
            cfg_q    <= '0;
            err_q    <= 1'b0;
            fill_cnt <= '0;
        end else begin
            unique case (state_q)
                FS_SAMPLE: begin
                    cfg_q   <= cfg_in;
                    err_q   <= !idx_legal(cfg_in.idx);
                    state_q <= FS_FILL;
                end
                FS_FILL: begin
                    if (!stall) begin
                        fill_cnt <= fill_cnt + 1'b1;
                        if (last_ent) begin
                            state_q <= FS_READY;
                        end
                    end
                end
                default: state_q <= FS_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tbl[wr_addr] <= wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld && (state_q == FS_READY);
        end
    end

    always_ff @(posedge clk) begin
        out_sym <= tbl[in_sym];
    end

    assign ready = (state_q == FS_READY);
    assign err   = err_q;

    // R7
    early_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(ready));

    // R11
    out_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(in_vld));

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != FS_SAMPLE) |=> $stable(cfg_q));

    // R6
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R6
    ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(fill_cnt) == W'(N - 1) && !$past(stall)));

    // R8
    err_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && out_vld) |-> (out_sym == $past(in_sym)));

endmodule

// File: rtl/perm_sel.sv
module perm_sel
    import perm_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       cfg_fwd,
    input  logic [5:0]       cfg_ret,
    input  logic             ld_en,
    input  logic [4:0]       ld_map,
    input  logic [5:0]       ld_entry,
    input  logic [5:0]       ld_data,
    input  logic             fwd_in_vld,
    input  logic [5:0]       fwd_in_sym,
    output logic             fwd_out_vld,
    output logic [5:0]       fwd_out_sym,
    input  logic             ret_in_vld,
    input  logic [5:0]       ret_in_sym,
    output logic             ret_out_vld,
    output logic [5:0]       ret_out_sym,
    output logic             fwd_ready,
    output logic             ret_ready,
    output logic             fwd_err,
    output logic             ret_err
);

    cfg_t cfg_a     [NUM_PATHS];
    idx_t rd_map    [NUM_PATHS];
    sym_t rd_ent    [NUM_PATHS];
    sym_t rd_data   [NUM_PATHS];
    logic in_vld_a  [NUM_PATHS];
    sym_t in_sym_a  [NUM_PATHS];
    logic out_vld_a [NUM_PATHS];
    sym_t out_sym_a [NUM_PATHS];
    logic rdy_a     [NUM_PATHS];
    logic err_a     [NUM_PATHS];
    logic all_rdy;
    logic ld_acc;

    assign cfg_a[PATH_FWD]    = cfg_t'(cfg_fwd);
    assign cfg_a[PATH_RET]    = cfg_t'(cfg_ret);
    assign in_vld_a[PATH_FWD] = fwd_in_vld;
    assign in_vld_a[PATH_RET] = ret_in_vld;
    assign in_sym_a[PATH_FWD] = fwd_in_sym;
    assign in_sym_a[PATH_RET] = ret_in_sym;

    always_comb begin
        all_rdy = 1'b1;
        for (int p = 0; p < NUM_PATHS; p++) begin
            all_rdy = all_rdy && rdy_a[p];
        end
        ld_acc = ld_en && !all_rdy;
    end

    perm_map_store #(
        .N_MAPS (NUM_MAPS),
        .N_RD   (NUM_PATHS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ld_acc),
        .wr_map  (ld_map),
        .wr_ent  (ld_entry),
        .wr_data (ld_data),
        .rd_map  (rd_map),
        .rd_ent  (rd_ent),
        .rd_data (rd_data)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        perm_path #(
            .W (SYM_W)
        ) u_path (
            .clk     (clk),
            .rst     (rst),
            .cfg_in  (cfg_a[p]),
            .stall   (ld_en),
            .rd_map  (rd_map[p]),
            .rd_ent  (rd_ent[p]),
            .rd_data (rd_data[p]),
            .in_vld  (in_vld_a[p]),
            .in_sym  (in_sym_a[p]),
            .out_vld (out_vld_a[p]),
            .out_sym (out_sym_a[p]),
            .ready   (rdy_a[p]),
            .err     (err_a[p])
        );
    end

    assign fwd_out_vld = out_vld_a[PATH_FWD];
    assign fwd_out_sym = out_sym_a[PATH_FWD];
    assign ret_out_vld = out_vld_a[PATH_RET];
    assign ret_out_sym = out_sym_a[PATH_RET];
    assign fwd_ready   = rdy_a[PATH_FWD];
    assign ret_ready   = rdy_a[PATH_RET];
    assign fwd_err     = err_a[PATH_FWD];
    assign ret_err     = err_a[PATH_RET];

    // R9
    load_window_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_ready && ret_ready) |-> !u_store.wr_ok);

endmodule

// File: tb/perm_sel_bench.sv
module perm_sel_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] cfg_fwd = '0, cfg_ret = '0;
    logic       ld_en = 1'b0;
    logic [4:0] ld_map = '0;
    logic [5:0] ld_entry = '0, ld_data = '0;
    logic       fwd_in_vld = 1'b0, ret_in_vld = 1'b0;
    logic [5:0] fwd_in_sym = '0, ret_in_sym = '0;
    logic       fwd_out_vld, ret_out_vld;
    logic [5:0] fwd_out_sym, ret_out_sym;
    logic       fwd_ready, ret_ready, fwd_err, ret_err;

    always #4 clk = ~clk;

    perm_sel u_perm_sel (
        .clk(clk), .rst(rst), .cfg_fwd(cfg_fwd), .cfg_ret(cfg_ret),
        .ld_en(ld_en), .ld_map(ld_map), .ld_entry(ld_entry), .ld_data(ld_data),
        .fwd_in_vld(fwd_in_vld), .fwd_in_sym(fwd_in_sym),
        .fwd_out_vld(fwd_out_vld), .fwd_out_sym(fwd_out_sym),
        .ret_in_vld(ret_in_vld), .ret_in_sym(ret_in_sym),
        .ret_out_vld(ret_out_vld), .ret_out_sym(ret_out_sym),
        .fwd_ready(fwd_ready), .ret_ready(ret_ready),
        .fwd_err(fwd_err), .ret_err(ret_err)
    );

    typedef struct {
        int    sym;
        string req;
    } exp_t;

    exp_t fq[$];
    exp_t rq[$];
    exp_t fe, re;
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    function automatic int mp(input int m, input int i);
        return ((2 * m + 1) * i + 5 * m + 3) % 64;
    endfunction

    function automatic int inv(input int m, input int s);
        for (int j = 0; j < 64; j++) begin
            if (mp(m, j) == s) return j;
        end
        return -1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (fwd_out_vld) begin
                if (fq.size() == 0) begin
                    chk("R7 fwd unexpected output valid", 1, 0);
                end else begin
                    fe = fq.pop_front();
                    chk(fe.req, int'(fwd_out_sym), fe.sym);
                end
            end
            if (ret_out_vld) begin
                if (rq.size() == 0) begin
                    chk("R7 ret unexpected output valid", 1, 0);
                end else begin
                    re = rq.pop_front();
                    chk(re.req, int'(ret_out_sym), re.sym);
                end
            end
        end
    end

    // driver: one character on each path, expected results pushed
    task automatic send(input int fs, input int fx, input string fr,
                        input int rs, input int rx, input string rr);
        exp_t a, b;
        @(posedge clk); #1;
        fwd_in_vld = 1'b1; fwd_in_sym = 6'(fs);
        ret_in_vld = 1'b1; ret_in_sym = 6'(rs);
        a.sym = fx; a.req = fr; fq.push_back(a);
        b.sym = rx; b.req = rr; rq.push_back(b);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        fwd_in_vld = 1'b0;
        ret_in_vld = 1'b0;
    endtask

    task automatic do_reset(input logic [5:0] cf, input logic [5:0] cr, input logic hold);
        @(posedge clk); #1;
        rst = 1'b1; cfg_fwd = cf; cfg_ret = cr; ld_en = hold;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic drain();
        repeat (4) idle();
        chk("R11 fwd queue drained", fq.size(), 0);
        chk("R11 ret queue drained", rq.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int n;
        // Scenario A: map 3 forward on fwd path, map 3 inverse on ret path
        cfg_fwd = {1'b0, 5'd3};
        cfg_ret = {1'b1, 5'd3};
        ld_en   = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R6 reset fwd_ready", fwd_ready, 0);
        chk("R6 reset ret_ready", ret_ready, 0);
        chk("R7 reset fwd_out_vld", fwd_out_vld, 0);
        chk("R7 reset ret_out_vld", ret_out_vld, 0);
        @(posedge clk); #1 rst = 1'b0;

        // R9 R10: fill the store while the paths are not ready
        for (int m = 0; m < 21; m++) begin
            for (int i = 0; i < 64; i++) begin
                @(posedge clk); #1;
                ld_map = 5'(m); ld_entry = 6'(i); ld_data = 6'(mp(m, i));
            end
        end
        @(negedge clk);
        chk("R6 fill held by load", fwd_ready, 0);
        chk("R1 fwd_err legal index", fwd_err, 0);
        chk("R1 ret_err legal index", ret_err, 0);
        @(posedge clk); #1 ld_en = 1'b0;

        // R6 R7: count fill edges while offering input
        n = 0;
        forever begin
            @(posedge clk); #1;
            fwd_in_vld = 1'b1; fwd_in_sym = 6'(n);
            ret_in_vld = 1'b1; ret_in_sym = 6'(n);
            n++;
            @(negedge clk);
            if (fwd_ready) begin
                fwd_in_vld = 1'b0; ret_in_vld = 1'b0;
                break;
            end
            chk("R7 fwd valid low while filling", fwd_out_vld, 0);
            if (n > 200) break;
        end
        chk("R6 fill edges after load release", n, 64);
        chk("R6 ret_ready with fwd_ready", ret_ready, 1);

        // R2 R3 R4: full sweep of both paths
        for (int s = 0; s < 64; s++) begin
            send(s, mp(3, s), "R2 forward map 3", s, inv(3, s), "R3 inverse map 3");
        end
        idle();
        // R11: a gap then a back-to-back pair
        idle();
        send(10, mp(3, 10), "R11 after gap", 63, inv(3, 63), "R11 after gap");
        send(0, mp(3, 0), "R11 back to back", 1, inv(3, 1), "R11 back to back");
        drain();

        // R5: configuration changes after sampling are ignored
        cfg_fwd = {1'b1, 5'd9};
        cfg_ret = {1'b0, 5'd30};
        for (int s = 5; s < 15; s++) begin
            send(s, mp(3, s), "R5 fwd cfg change ignored", s, inv(3, s), "R5 ret cfg change ignored");
        end
        drain();
        chk("R5 ret_err unchanged", ret_err, 0);

        // R9: a load after ready leaves the store untouched
        @(posedge clk); #1;
        ld_en = 1'b1; ld_map = 5'd3; ld_entry = 6'd0; ld_data = 6'((mp(3, 0) + 1) % 64);
        repeat (3) @(posedge clk);
        #1 ld_en = 1'b0;
        send(0, mp(3, 0), "R9 late load ignored", mp(3, 0), 0, "R9 late load ignored");
        drain();

        // Scenario B: map 20 inverse on fwd, reserved 25 on ret, no load hold
        do_reset({1'b1, 5'd20}, {1'b0, 5'd25}, 1'b0);
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (fwd_ready || n > 200) break;
        end
        chk("R6 ready after release edges", n, 65);
        chk("R8 ret_err reserved index", ret_err, 1);
        chk("R8 fwd_err legal index", fwd_err, 0);
        chk("R6 ret_ready reserved path", ret_ready, 1);
        for (int s = 0; s < 64; s++) begin
            send(s, inv(20, s), "R3 inverse map 20", 63 - s, 63 - s, "R8 reserved pass-through");
        end
        drain();

        // Scenario C: both paths on map 3 forward after another reset
        do_reset({1'b0, 5'd3}, {1'b0, 5'd3}, 1'b0);
        repeat (66) @(posedge clk);
        @(negedge clk);
        chk("R4 fwd_ready same map", fwd_ready, 1);
        chk("R8 ret_err cleared", ret_err, 0);
        for (int s = 0; s < 64; s++) begin
            send(s, mp(3, s), "R10 store kept over reset", (s * 7) % 64, mp(3, (s * 7) % 64), "R4 shared map");
        end
        drain();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule